// File: doc/BRIEF.md
# Dual-Tone Spur Correction Generator

This block synthesises a digital correction signal that cancels up to two known spurious tones on a main frequency-synthesis output. Each of its two channels owns a small phase accumulator, a sine lookup and an amplitude scaler. Every channel is programmed with a tuning word, a phase offset and an amplitude. Its tone is produced in anti-phase: half a cycle is added to the phase before lookup. When the correction is summed with the main output, the targeted spur is therefore reduced.

Channel settings are written into a shadow bank, one channel at a time. A single update strobe moves both channels' shadow settings into the running bank in the same cycle. The two scaled tones are added together and clipped to a signed 10-bit correction word. The latency from accumulator to output is fixed at three registers, so the correction can be kept aligned with the main path.

Top module: `spur_cancel_gen`

## Requirements
- R1: After reset, corr_o is 0 (signed two's complement), both channels are disabled and all accumulators and settings are zero.
- R2: On every clock, each channel's accumulator advances by its running tuning word, modulo 2^ACC_W, whether or not the channel is enabled.
- R3: The lookup index is the top LUT_AW bits of (accumulator + phase offset + 2^(ACC_W-1)) mod 2^ACC_W. Table entry k is round(511*sin(2*pi*k/64)) for the defaults, so offset 0x4000 reads -511 and offset 0xC000 reads +511.
- R4: A channel's contribution is floor(sine * amp / 2^AMP_W), with amp taken as unsigned. For example, -511 at amp 128 gives -256.
- R5: A disabled channel contributes 0 to the sum.
- R6: The sum of both contributions saturates to the range -512..511 and never wraps.
- R7: A write stores en, tuning word, phase and amp in the shadow bank of the channel chosen by cfg_ch_i, and does not change the output. update_i copies both shadow banks into the running banks on the same edge.
- R8: A phase change loaded on update edge E first appears on corr_o after edge E+3. The output after E+2 still reflects the old settings.
- R9: cfg_ch_i = 0 addresses channel 0 and cfg_ch_i = 1 addresses channel 1. A write to one channel leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Shadow write strobe |
| cfg_ch_i | input | 1 | Channel select for the write |
| cfg_en_i | input | 1 | Channel enable value |
| cfg_ftw_i | input | 16 | Tuning word value |
| cfg_phase_i | input | 16 | Phase offset value |
| cfg_amp_i | input | 8 | Unsigned amplitude value |
| update_i | input | 1 | Copy all shadow settings into the running banks |
| corr_o | output | 10 | Signed saturated correction sample |

## Verification
Zero tuning words with chosen phase offsets hold the output at a fixed table entry. This separates the anti-phase offset, the rounding toward negative infinity in scaling, and the saturation at both limits. A single channel enabled on each side confirms that channel select and disable gating work. A shadow write followed by a delayed update shows that staged settings stay inert until the strobe, and the exact cycle of the change pins the latency. Long runs of random writes and updates, compared cycle by cycle against a bench model, exercise accumulator wrap, an update between writes and mixed phase motion. A tuning word that steps one table entry per cycle must repeat every 64 cycles, which confirms modular accumulation.

// File: rtl/spur_pkg.sv
package spur_pkg;
  localparam int ACC_W  = 16;
  localparam int LUT_AW = 6;
  localparam int SIN_W  = 10;
  localparam int AMP_W  = 8;
  localparam int OUT_W  = 10;
  localparam int N_CH   = 2;

  // rounded sine sample, full-scale 2^(w-1)-1, n entries per cycle
  function automatic int sine_q(int k, int n, int w);
    real pk;
    real x;
    pk = 2.0 * 3.14159265358979323846 * real'(k) / real'(n);
    x  = $sin(pk) * real'((1 << (w - 1)) - 1);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction
endpackage

// File: rtl/spur_cfg_bank.sv
module spur_cfg_bank #(
  parameter int ACC_W = spur_pkg::ACC_W,
  parameter int AMP_W = spur_pkg::AMP_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             en_i,
  input  logic [ACC_W-1:0] ftw_i,
  input  logic [ACC_W-1:0] phase_i,
  input  logic [AMP_W-1:0] amp_i,
  input  logic             update_i,
  output logic             en_o,
  output logic [ACC_W-1:0] ftw_o,
  output logic [ACC_W-1:0] phase_o,
  output logic [AMP_W-1:0] amp_o
);
  logic             sh_en;
  logic [ACC_W-1:0] sh_ftw, sh_ph;
  logic [AMP_W-1:0] sh_amp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_en  <= 1'b0;
      sh_ftw <= '0;
      sh_ph  <= '0;
      sh_amp <= '0;
    end else if (we_i) begin
      sh_en  <= en_i;
      sh_ftw <= ftw_i;
      sh_ph  <= phase_i;
      sh_amp <= amp_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o    <= 1'b0;
      ftw_o   <= '0;
      phase_o <= '0;
      amp_o   <= '0;
    end else if (update_i) begin
      en_o    <= sh_en;
      ftw_o   <= sh_ftw;
      phase_o <= sh_ph;
      amp_o   <= sh_amp;
    end
  end

  // R7: running bank moves only on the strobe, and then as a whole
  a_r7_hold_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_i |=> $stable({en_o, ftw_o, phase_o, amp_o}));
  a_r7_load_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i |=> {en_o, ftw_o, phase_o, amp_o} == $past({sh_en, sh_ftw, sh_ph, sh_amp}));
endmodule

// File: rtl/spur_tone_chan.sv
module spur_tone_chan #(
  parameter int ACC_W  = spur_pkg::ACC_W,
  parameter int LUT_AW = spur_pkg::LUT_AW,
  parameter int SIN_W  = spur_pkg::SIN_W,
  parameter int AMP_W  = spur_pkg::AMP_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic [ACC_W-1:0]        ftw_i,
  input  logic [ACC_W-1:0]        phase_i,
  input  logic [AMP_W-1:0]        amp_i,
  output logic signed [SIN_W-1:0] tone_o
);
  localparam int LUT_N  = 1 << LUT_AW;
  localparam int PROD_W = SIN_W + AMP_W + 1;
  localparam logic [ACC_W-1:0] HALF = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [SIN_W-1:0] lut [LUT_N];
  for (genvar k = 0; k < LUT_N; k++) begin : g_lut
    localparam int SV = spur_pkg::sine_q(k, LUT_N, SIN_W);
    assign lut[k] = SIN_W'(SV);
  end

  logic [ACC_W-1:0]         acc_q, ph_sum;
  logic [LUT_AW-1:0]        addr;
  logic signed [SIN_W-1:0]  sin_q;
  logic signed [PROD_W-1:0] prod_full, prod_scl;

  always_comb begin
    ph_sum    = acc_q + phase_i + HALF;   // half-cycle shift = anti-phase
    addr      = ph_sum[ACC_W-1 -: LUT_AW];
    prod_full = PROD_W'(sin_q) * $signed({1'b0, amp_i});
    prod_scl  = prod_full >>> AMP_W;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      sin_q  <= '0;
      tone_o <= '0;
    end else begin
      acc_q  <= acc_q + ftw_i;
      sin_q  <= lut[addr];
      tone_o <= en_i ? prod_scl[SIN_W-1:0] : '0;
    end
  end

  a_r2_acc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> acc_q == ACC_W'($past(acc_q) + $past(ftw_i)));
  a_r5_off_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> tone_o == '0);
endmodule

// File: rtl/spur_sum_sat.sv
module spur_sum_sat #(
  parameter int N_CH  = spur_pkg::N_CH,
  parameter int SIN_W = spur_pkg::SIN_W,
  parameter int OUT_W = spur_pkg::OUT_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [SIN_W-1:0] tone_i [N_CH],
  output logic signed [OUT_W-1:0] corr_o
);
  localparam int SUM_W = SIN_W + $clog2(N_CH) + 1;
  localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] MINV = -SUM_W'(1 << (OUT_W - 1));

  logic signed [SUM_W-1:0] sum_w;
  logic signed [OUT_W-1:0] sat_w;

  always_comb begin
    sum_w = '0;
    for (int c = 0; c < N_CH; c++) sum_w = sum_w + SUM_W'(tone_i[c]);
    if (sum_w > MAXV)      sat_w = MAXV[OUT_W-1:0];
    else if (sum_w < MINV) sat_w = MINV[OUT_W-1:0];
    else                   sat_w = sum_w[OUT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) corr_o <= '0;
    else         corr_o <= sat_w;
  end

  a_r6_clip_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_w > MAXV) |=> corr_o == MAXV[OUT_W-1:0]);
  a_r6_clip_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_w < MINV) |=> corr_o == MINV[OUT_W-1:0]);
endmodule

// File: rtl/spur_cancel_gen.sv
module spur_cancel_gen #(
  parameter int ACC_W  = spur_pkg::ACC_W,
  parameter int LUT_AW = spur_pkg::LUT_AW,
  parameter int SIN_W  = spur_pkg::SIN_W,
  parameter int AMP_W  = spur_pkg::AMP_W,
  parameter int OUT_W  = spur_pkg::OUT_W,
  parameter int N_CH   = spur_pkg::N_CH,
  localparam int CH_AW = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_we_i,
  input  logic [CH_AW-1:0]        cfg_ch_i,
  input  logic                    cfg_en_i,
  input  logic [ACC_W-1:0]        cfg_ftw_i,
  input  logic [ACC_W-1:0]        cfg_phase_i,
  input  logic [AMP_W-1:0]        cfg_amp_i,
  input  logic                    update_i,
  output logic signed [OUT_W-1:0] corr_o
);
  logic signed [SIN_W-1:0] tone [N_CH];

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic             act_en;
    logic [ACC_W-1:0] act_ftw, act_ph;
    logic [AMP_W-1:0] act_amp;
    logic             we_c;

    assign we_c = cfg_we_i && (cfg_ch_i == CH_AW'(c));

    spur_cfg_bank #(.ACC_W(ACC_W), .AMP_W(AMP_W)) u_cfg (
      .clk_i, .rst_ni, .we_i(we_c), .en_i(cfg_en_i), .ftw_i(cfg_ftw_i),
      .phase_i(cfg_phase_i), .amp_i(cfg_amp_i), .update_i,
      .en_o(act_en), .ftw_o(act_ftw), .phase_o(act_ph), .amp_o(act_amp));

    spur_tone_chan #(.ACC_W(ACC_W), .LUT_AW(LUT_AW), .SIN_W(SIN_W), .AMP_W(AMP_W)) u_tone (
      .clk_i, .rst_ni, .en_i(act_en), .ftw_i(act_ftw), .phase_i(act_ph),
      .amp_i(act_amp), .tone_o(tone[c]));
  end

  spur_sum_sat #(.N_CH(N_CH), .SIN_W(SIN_W), .OUT_W(OUT_W)) u_sum (
    .clk_i, .rst_ni, .tone_i(tone), .corr_o);
endmodule

// File: tb/spur_cancel_gen_tb.sv
module spur_cancel_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [0:0]  cfg_ch_i = '0;
  logic        cfg_en_i = 1'b0;
  logic [15:0] cfg_ftw_i = '0;
  logic [15:0] cfg_phase_i = '0;
  logic [7:0]  cfg_amp_i = '0;
  logic        update_i = 1'b0;
  logic signed [9:0] corr_o;

  int n_chk = 0;
  int n_fail = 0;

  spur_cancel_gen u_dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // reference model built from the requirements
  int sh_en[2], sh_ftw[2], sh_ph[2], sh_amp[2];
  int ac_en[2], ac_ftw[2], ac_ph[2], ac_amp[2];
  int m_acc[2], m_sin[2], m_prod[2];
  int m_out;

  function automatic int ref_sin(int k);
    real x;
    x = $sin(2.0 * 3.14159265358979323846 * real'(k) / 64.0) * 511.0;
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  function automatic int sat10(int v);
    return (v > 511) ? 511 : (v < -512) ? -512 : v;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < 2; c++) begin
        sh_en[c] <= 0; sh_ftw[c] <= 0; sh_ph[c] <= 0; sh_amp[c] <= 0;
        ac_en[c] <= 0; ac_ftw[c] <= 0; ac_ph[c] <= 0; ac_amp[c] <= 0;
        m_acc[c] <= 0; m_sin[c] <= 0; m_prod[c] <= 0;
      end
      m_out <= 0;
    end else begin
      for (int c = 0; c < 2; c++) begin
        if (cfg_we_i && int'(cfg_ch_i) == c) begin
          sh_en[c] <= int'(cfg_en_i); sh_ftw[c] <= int'(cfg_ftw_i);
          sh_ph[c] <= int'(cfg_phase_i); sh_amp[c] <= int'(cfg_amp_i);
        end
        if (update_i) begin
          ac_en[c] <= sh_en[c]; ac_ftw[c] <= sh_ftw[c];
          ac_ph[c] <= sh_ph[c]; ac_amp[c] <= sh_amp[c];
        end
        m_acc[c]  <= (m_acc[c] + ac_ftw[c]) & 32'hFFFF;
        m_sin[c]  <= ref_sin(((m_acc[c] + ac_ph[c] + 32'h8000) & 32'hFFFF) >> 10);
        m_prod[c] <= (ac_en[c] != 0) ? ((m_sin[c] * ac_amp[c]) >>> 8) : 0;
      end
      m_out <= sat10(m_prod[0] + m_prod[1]);
    end
  end

  task automatic check(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(int ch, int en, int ftw, int ph, int amp);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_ch_i = 1'(ch); cfg_en_i = 1'(en);
    cfg_ftw_i = 16'(ftw); cfg_phase_i = 16'(ph); cfg_amp_i = 8'(amp);
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic upd();
    @(negedge clk_i);
    update_i = 1'b1;
    @(negedge clk_i);
    update_i = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int seed;
    int hist[64];
    seed = $urandom(32'h5a17);
    #(CLK_PERIOD * 2 + 3);
    check("R1 reset output", int'(corr_o), 0);
    rst_ni = 1'b1;
    idle(4);
    check("R1 idle after reset", int'(corr_o), 0);

    // R3 anti-phase lookup, R4 full amplitude
    wr(0, 1, 0, 16'h4000, 255); upd(); idle(5);
    check("R3/R4 offset 0x4000 amp 255", int'(corr_o), -510);

    // R8: phase-only change, old value through E+2, new at E+3
    wr(0, 1, 0, 16'hC000, 255);
    @(negedge clk_i); update_i = 1'b1;
    @(negedge clk_i); update_i = 1'b0;   // after edge E
    check("R8 after E", int'(corr_o), -510);
    @(negedge clk_i);
    check("R8 after E+1", int'(corr_o), -510);
    @(negedge clk_i);
    check("R8 after E+2", int'(corr_o), -510);
    @(negedge clk_i);
    check("R8 after E+3", int'(corr_o), 509);

    // R7 shadow write is inert until update
    wr(0, 1, 0, 16'h4000, 128); idle(6);
    check("R7 shadow inert", int'(corr_o), 509);
    upd(); idle(5);
    check("R4 floor -511*128", int'(corr_o), -256);

    // R6 saturation both limits
    wr(1, 1, 0, 16'h4000, 255); wr(0, 1, 0, 16'h4000, 255); upd(); idle(5);
    check("R6 low clip", int'(corr_o), -512);
    wr(0, 1, 0, 16'hC000, 255); wr(1, 1, 0, 16'hC000, 255); upd(); idle(5);
    check("R6 high clip", int'(corr_o), 511);

    // R5 disable, R9 channel select
    wr(0, 0, 0, 16'hC000, 255); upd(); idle(5);
    check("R5 ch0 off, R9 ch1 alone", int'(corr_o), 509);
    wr(1, 0, 0, 16'hC000, 255); upd(); idle(5);
    check("R5 both off", int'(corr_o), 0);
    wr(1, 1, 0, 16'hC000, 128); upd(); idle(5);
    check("R9 ch1 amp 128", int'(corr_o), 255);

    // R2 one table step per cycle: period 64
    wr(1, 0, 0, 0, 0); wr(0, 1, 16'h0400, 0, 200); upd(); idle(6);
    for (int i = 0; i < 64; i++) begin hist[i] = int'(corr_o); @(negedge clk_i); end
    for (int i = 0; i < 64; i++) begin
      check("R2 period 64", int'(corr_o), hist[i]);
      @(negedge clk_i);
    end

    // random mix compared to model every cycle
    for (int i = 0; i < 4000; i++) begin
      cfg_we_i = ($urandom % 5) == 0;
      cfg_ch_i = 1'($urandom);
      cfg_en_i = ($urandom % 4) != 0;
      cfg_ftw_i = 16'($urandom);
      cfg_phase_i = 16'($urandom);
      cfg_amp_i = (($urandom % 6) == 0) ? 8'hFF : 8'($urandom);
      update_i = ($urandom % 12) == 0;
      @(negedge clk_i);
      check("R8 model match", int'(corr_o), m_out);
    end
    cfg_we_i = 1'b0; update_i = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule